// File: doc/BRIEF.md
# Open-Drain General-Purpose Pin Port

This block controls a small group of package pins (six by default) through three 16-bit registers: a function-select register, a direction register and a data register. Each pin can act as a plain software-controlled pin or hand its pad to one of three alternate peripheral signals. In every mode the pad is open-drain. A pin is either pulled low or left at high impedance, and it is never driven high. The pad output value is tied to 0, and only the output-enable changes.

Software reads the data register to see pin state. For a pin set up as a plain output, the read returns the bit that software stored. For any other pin, the read returns the pad level after it has passed through a two-flop synchronizer. The synchronized levels also leave the block on a separate port so the alternate peripherals can use them. Writes land on the rising clock edge. Reads and pad controls are combinational from the stored state.

Top module: `gpio_od_port`

## Requirements
- R1: After reset, the function-select, direction and data registers all read 0, and no pad output-enable is asserted.
- R2: Unused register bits always read 0 and cannot be set by writes. These are bits 15..6 of the direction and data registers and bits 15..12 of the function-select register.
- R3: Every bit of pad_out is 0 at all times.
- R4: For a pin in plain mode (selector 00) with direction bit 1, pad_oe is 1 when its data bit is 0 and 0 when its data bit is 1. The change shows from the clock edge that accepts the write.
- R5: For a pin in plain mode with direction bit 0, pad_oe is 0 whatever its data bit. A write still updates the stored data bit, which reads back once the pin becomes an output.
- R6: Reading the data register for a plain-mode output pin returns the stored data bit, whatever the pad level.
- R7: For every other pin (plain-mode input or any alternate mode), a data read returns the pad level delayed by two clock edges.
- R8: The selector for pin i is at function-select bits 2i+1..2i: 00 is plain mode, and 01, 10, 11 pick alternate functions 1, 2, 3. In alternate function f, pad_oe[i] equals alt_oe[(f-1)*N+i] AND NOT alt_out[(f-1)*N+i], and the direction and data bits have no effect.
- R9: pin_sync[i] equals pad_in[i] as it was two clock edges earlier, in every mode.
- R10: The register addresses are 0 for function select, 1 for direction and 2 for data, with bit i belonging to pin i. Address 3 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 select, 1 direction, 2 data) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| pad_in | input | 6 | Pad input levels |
| pad_oe | output | 6 | Pad output-enable (pull low when 1) |
| pad_out | output | 6 | Pad output value, always 0 |
| alt_oe | input | 18 | Alternate function output-enables, function f at bits (f-1)*6 +: 6 |
| alt_out | input | 18 | Alternate function output values, same layout |
| pin_sync | output | 6 | Synchronized pad levels for peripherals |

## Verification
Every combination of direction bits is swept against four data patterns and a pad pattern that differs from the data. This separates pad_oe from the stored bit and shows whether each read-back bit came from the register or from the pad. Each alternate code is then applied to all pins with a range of enable/value pairs, while the unselected functions carry the opposite pattern. Any cross-routing between functions, or any leak from the direction bits, therefore changes the result. A mixed per-pin selector setting checks the bit placement of the selector fields. Single-edge sampling after a pad change tells a two-stage synchronizer apart from a shorter one.

// File: rtl/gpio_od_pkg.sv
package gpio_od_pkg;
   typedef enum logic [1:0] {
      FSEL_GPIO = 2'b00,
      FSEL_ALT1 = 2'b01,
      FSEL_ALT2 = 2'b10,
      FSEL_ALT3 = 2'b11
   } fsel_e;

   localparam int unsigned NUM_ALT   = 3;
   localparam int unsigned ADDR_SEL  = 0;
   localparam int unsigned ADDR_DIR  = 1;
   localparam int unsigned ADDR_DATA = 2;
endpackage

// File: rtl/gpio_od_sync.sv
module gpio_od_sync #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < int'(STAGES); k++) stage_q[k] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int k = 1; k < int'(STAGES); k++) stage_q[k] <= stage_q[k-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_od_regs.sv
module gpio_od_regs
   import gpio_od_pkg::*;
#(
   parameter int unsigned NUM_PINS = 6,
   parameter int unsigned REG_W    = 16,
   parameter int unsigned ADDR_W   = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [REG_W-1:0]      wdata,
   input  logic [NUM_PINS-1:0]   pin_lvl,
   output logic [REG_W-1:0]      rdata,
   output logic [2*NUM_PINS-1:0] sel_q,
   output logic [NUM_PINS-1:0]   dir_q,
   output logic [NUM_PINS-1:0]   data_q
);
   localparam int unsigned SEL_W = 2 * NUM_PINS;

   logic hit_sel, hit_dir, hit_data;
   assign hit_sel  = (addr == ADDR_W'(ADDR_SEL));
   assign hit_dir  = (addr == ADDR_W'(ADDR_DIR));
   assign hit_data = (addr == ADDR_W'(ADDR_DATA));

   generate
      if (SEL_W < REG_W) begin : g_spare
         logic unused_wbits;
         assign unused_wbits = ^wdata[REG_W-1:SEL_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         dir_q  <= '0;
         data_q <= '0;
      end else if (wr_en) begin
         if (hit_sel)  sel_q  <= wdata[SEL_W-1:0];
         if (hit_dir)  dir_q  <= wdata[NUM_PINS-1:0];
         if (hit_data) data_q <= wdata[NUM_PINS-1:0];
      end
   end

   logic [NUM_PINS-1:0] data_view;
   always_comb begin
      for (int i = 0; i < int'(NUM_PINS); i++) begin
         if (fsel_e'(sel_q[2*i +: 2]) == FSEL_GPIO && dir_q[i])
            data_view[i] = data_q[i];
         else
            data_view[i] = pin_lvl[i];
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_sel)       rdata[SEL_W-1:0]    = sel_q;
      else if (hit_dir)  rdata[NUM_PINS-1:0] = dir_q;
      else if (hit_data) rdata[NUM_PINS-1:0] = data_view;
   end
endmodule

// File: rtl/gpio_od_pinmux.sv
module gpio_od_pinmux
   import gpio_od_pkg::*;
(
   input  logic [1:0]         fsel,
   input  logic               dir,
   input  logic               dat,
   input  logic [NUM_ALT-1:0] alt_oe,
   input  logic [NUM_ALT-1:0] alt_out,
   output logic               oe
);
   always_comb begin
      unique case (fsel_e'(fsel))
         FSEL_GPIO: oe = dir & ~dat;
         FSEL_ALT1: oe = alt_oe[0] & ~alt_out[0];
         FSEL_ALT2: oe = alt_oe[1] & ~alt_out[1];
         FSEL_ALT3: oe = alt_oe[2] & ~alt_out[2];
         default:   oe = 1'b0;
      endcase
   end
endmodule

// File: rtl/gpio_od_port.sv
module gpio_od_port
   import gpio_od_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 6,
   parameter int unsigned REG_W       = 16,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr_en,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic [REG_W-1:0]              reg_wdata,
   output logic [REG_W-1:0]              reg_rdata,
   input  logic [NUM_PINS-1:0]           pad_in,
   output logic [NUM_PINS-1:0]           pad_oe,
   output logic [NUM_PINS-1:0]           pad_out,
   input  logic [NUM_ALT*NUM_PINS-1:0]   alt_oe,
   input  logic [NUM_ALT*NUM_PINS-1:0]   alt_out,
   output logic [NUM_PINS-1:0]           pin_sync
);
   generate
      if (NUM_PINS < 1 || 2 * NUM_PINS > REG_W) begin : g_bad_pins
         $error("gpio_od_port: selector fields do not fit the register width");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("gpio_od_port: address too narrow for three registers");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_od_port: at least two synchronizer stages required");
      end
   endgenerate

   logic [2*NUM_PINS-1:0] sel_q;
   logic [NUM_PINS-1:0]   dir_q;
   logic [NUM_PINS-1:0]   data_q;

   gpio_od_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   gpio_od_regs #(.NUM_PINS(NUM_PINS), .REG_W(REG_W), .ADDR_W(ADDR_W)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .pin_lvl (pin_sync),
      .rdata   (reg_rdata),
      .sel_q   (sel_q),
      .dir_q   (dir_q),
      .data_q  (data_q)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic [NUM_ALT-1:0] p_oe, p_out;
      for (genvar f = 0; f < NUM_ALT; f++) begin : g_fn
         assign p_oe[f]  = alt_oe[f*NUM_PINS + i];
         assign p_out[f] = alt_out[f*NUM_PINS + i];
      end
      gpio_od_pinmux mux_i (
         .fsel    (sel_q[2*i +: 2]),
         .dir     (dir_q[i]),
         .dat     (data_q[i]),
         .alt_oe  (p_oe),
         .alt_out (p_out),
         .oe      (pad_oe[i])
      );
   end

   assign pad_out = '0;
endmodule

// File: rtl/gpio_od_port_chk.sv
module gpio_od_port_chk #(
   parameter int unsigned NUM_PINS    = 6,
   parameter int unsigned REG_W       = 16,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       reg_addr,
   input logic [REG_W-1:0]        reg_rdata,
   input logic [NUM_PINS-1:0]     pad_in,
   input logic [NUM_PINS-1:0]     pad_oe,
   input logic [NUM_PINS-1:0]     pad_out,
   input logic [3*NUM_PINS-1:0]   alt_oe,
   input logic [NUM_PINS-1:0]     pin_sync,
   input logic [2*NUM_PINS-1:0]   sel_q,
   input logic [NUM_PINS-1:0]     dir_q,
   input logic [NUM_PINS-1:0]     data_q
);
   logic [1:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |-> (pad_oe == '0));

   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(1) || reg_addr == ADDR_W'(2)) |-> (reg_rdata[REG_W-1:NUM_PINS] == '0));

   assert_never_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pad_out == '0);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin_chk
      assert_release_on_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_q[2*i +: 2] == 2'b00 && dir_q[i] && data_q[i]) |-> !pad_oe[i]);

      assert_input_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_q[2*i +: 2] == 2'b00 && !dir_q[i]) |-> !pad_oe[i]);

      assert_alt_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_q[2*i +: 2] != 2'b00 &&
          !alt_oe[(32'(sel_q[2*i +: 2]) - 1) * NUM_PINS + i]) |-> !pad_oe[i]);
   end

   generate
      if (SYNC_STAGES == 2) begin : g_sync_chk
         assert_sync_delay_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2) |-> (pin_sync == $past(pad_in, 2)));
      end
   endgenerate
endmodule

bind gpio_od_port gpio_od_port_chk #(
   .NUM_PINS(NUM_PINS), .REG_W(REG_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_rdata (reg_rdata),
   .pad_in    (pad_in),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .alt_oe    (alt_oe),
   .pin_sync  (pin_sync),
   .sel_q     (sel_q),
   .dir_q     (dir_q),
   .data_q    (data_q)
);

// File: tb/gpio_od_port_tb.sv
module gpio_od_port_tb_top;
   localparam int N = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr_en = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic [N-1:0]  pad_in = '0;
   logic [N-1:0]  pad_oe;
   logic [N-1:0]  pad_out;
   logic [3*N-1:0] alt_oe = '0;
   logic [3*N-1:0] alt_out = '0;
   logic [N-1:0]  pin_sync;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_od_port dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .alt_oe(alt_oe), .alt_out(alt_out),
      .pin_sync(pin_sync)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] r;
      logic [N-1:0] exp_oe;
      logic [11:0] selw;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(2'd0, r); check("R1 sel", r, 16'h0);
      rd(2'd1, r); check("R1 dir", r, 16'h0);
      rd(2'd2, r); check("R1 data", r, 16'h0);
      check("R1 oe", 16'(pad_oe), 16'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reserved bits
      wr(2'd1, 16'hFFFF); rd(2'd1, r); check("R2 dir", r, 16'h003F);
      wr(2'd0, 16'hFFFF); rd(2'd0, r); check("R2 sel", r, 16'h0FFF);
      wr(2'd0, 16'h0000);
      wr(2'd2, 16'hFFC0); rd(2'd2, r); check("R2 data", r, 16'h0000);

      // R10 address 3
      wr(2'd3, 16'hFFFF); rd(2'd3, r); check("R10 addr3", r, 16'h0);
      rd(2'd0, r); check("R10 sel untouched", r, 16'h0);
      rd(2'd1, r); check("R10 dir untouched", r, 16'h003F);

      // R5 write while input stored
      wr(2'd1, 16'h0000);
      pad_in = 6'h2A; wr(2'd2, 16'h0015); settle();
      check("R5 no drive", 16'(pad_oe), 16'h0);
      rd(2'd2, r); check("R7 input reads pad", r, 16'h002A);
      wr(2'd1, 16'h003F); rd(2'd2, r); check("R5 stored bit", r, 16'h0015);

      // R4/R6/R7 sweep
      for (int d = 0; d < 64; d++) begin
         for (int p = 0; p < 4; p++) begin
            logic [N-1:0] v, pin;
            v = 6'((p * 21 + d * 5) & 63);
            pin = ~v ^ 6'(p);
            pad_in = pin;
            wr(2'd1, 16'(d));
            wr(2'd2, 16'(v));
            check("R4 R5 oe", 16'(pad_oe), 16'(6'(d) & ~v));
            check("R3 out", 16'(pad_out), 16'h0);
            settle();
            rd(2'd2, r);
            check("R6 R7 readback", r, 16'((6'(d) & v) | (~6'(d) & pin)));
         end
      end

      // R8 uniform alt codes
      wr(2'd1, 16'h003F); wr(2'd2, 16'h0000);
      for (int f = 1; f <= 3; f++) begin
         selw = '0;
         for (int i = 0; i < N; i++) selw[2*i +: 2] = 2'(f);
         wr(2'd0, 16'(selw));
         for (int p = 0; p < 16; p++) begin
            logic [N-1:0] o, v;
            o = 6'((p * 7 + 3) & 63);
            v = 6'((p * 13) & 63);
            for (int g = 0; g < 3; g++) begin
               alt_oe[g*N +: N]  = (g == f-1) ? o : ~o;
               alt_out[g*N +: N] = (g == f-1) ? v : ~v;
            end
            #1;
            check("R8 alt oe", 16'(pad_oe), 16'(o & ~v));
         end
         pad_in = 6'h19; settle(); rd(2'd2, r);
         check("R7 alt read pad", r, 16'h0019);
      end

      // R8 mixed selectors: pin i code i%4
      selw = '0;
      for (int i = 0; i < N; i++) selw[2*i +: 2] = 2'(i % 4);
      wr(2'd0, 16'(selw));
      rd(2'd0, r); check("R8 sel layout", r, 16'(selw));
      for (int p = 0; p < 8; p++) begin
         alt_oe = 18'((p * 40503) & 18'h3FFFF);
         alt_out = 18'((p * 9973) & 18'h3FFFF);
         #1;
         for (int i = 0; i < N; i++) begin
            int c;
            c = i % 4;
            exp_oe[i] = (c == 0) ? 1'b1 : (alt_oe[(c-1)*N+i] & ~alt_out[(c-1)*N+i]);
         end
         check("R8 mixed oe", 16'(pad_oe), 16'(exp_oe));
      end

      // R9 synchronizer depth
      @(negedge clk); pad_in = 6'h00; settle();
      pad_in = 6'h3F;
      @(negedge clk); check("R9 one edge", 16'(pin_sync), 16'h0);
      @(negedge clk); check("R9 two edges", 16'(pin_sync), 16'h003F);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule